// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This peripheral takes a wide bank of pad inputs and lets software route any one of them onto each of eight interrupt channels. Each channel then conditions its selected pad and drives a single active-high line toward an upstream interrupt controller. Channel conditioning covers several trigger types:

- level, with an optional inverter for active-low sources;
- rising or falling single-edge detection, where the inverter turns a falling edge into a rising one;
- both-edges detection, which ignores the single-edge and polarity settings.

Software configures the block through four 32-bit registers, each addressed by a two-bit word index. A write strobe commits the write data on a clock edge. Read data is combinational and follows the index.

Inside each channel the selected pad passes through a synchronizer, then the inverter, then a small state machine.

- **States.** The state machine has three states: `ST_FLUSH`, `ST_WATCH_LO` and `ST_WATCH_HI`.
- **Reset and reconfiguration.** Reset enters `ST_FLUSH`, and so does any write that can change the channel's source or trigger type (transition *reload*).
- **Leaving `ST_FLUSH`.** The state machine stays in `ST_FLUSH` until the synchronizer holds only samples of the new source. It then moves to `ST_WATCH_HI` or `ST_WATCH_LO` to match the conditioned input, and raises no interrupt on the way (transition *settle*).
- **`ST_WATCH_LO`.** From this state a high input moves to `ST_WATCH_HI` (transition *rise*). This fires a pulse in any edge mode.
- **`ST_WATCH_HI`.** From this state a low input moves back to `ST_WATCH_LO` (transition *fall*). This fires a pulse only in both-edges mode.
- **Output register.** A separate output register presents either the pulse or the conditioned level.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset all four registers read zero, and every channel output is low while reset is asserted.
- R2: The register at word index 0 holds the trigger configuration in bits 23:0. Writing all ones to it reads back 0x00FFFFFF, because bits 31:24 always read zero. The registers at indices 1, 2 and 3 read back all 32 written bits.
- R3: Word index 1 holds the pad numbers for channels 0 to 3 and word index 2 holds those for channels 4 to 7. Channel c uses the 8-bit field at bit (c mod 4)*8 of its register. Any pad 0 to 255 can be routed to any channel, and a pad change appears only on the channels that select that pad.
- R4: Word index 3 stores a 4-bit filter code for channel c at bit c*4. Writing it does not change any channel output.
- R5: With bits c, 8+c and 16+c of index 0 all clear, channel c is in level mode. The output follows the pad as an active-high level, and a pad change made just after clock edge N shows on the output after edge N+3.
- R6: Setting bit 16+c in level mode inverts channel c, so a low pad drives the output high, with the same latency as R5.
- R7: Setting bit c with bit 8+c clear selects single-edge mode. A rising conditioned input produces a pulse exactly one clock wide after edge N+3, and a falling input produces nothing.
- R8: Setting both bit c and bit 16+c makes channel c report falling pad edges as one-clock pulses, and rising pad edges produce nothing.
- R9: Setting bit 8+c makes channel c pulse for one clock on every pad edge, rising or falling, whatever bits c and 16+c hold. It never produces a level in this mode.
- R10: Any write to index 0, or to the pin-select register that holds channel c, restarts channel c's edge history. In an edge mode no pulse appears from the reconfiguration itself, even when the new source is already high. Detection resumes normally afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and channel logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, data committed on the rising clock edge |
| reg_idx | input | 2 | Word index of the accessed register (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at reg_idx, combinational |
| pads | input | NUM_PADS | Asynchronous pad inputs, NUM_PADS defaults to 256 |
| irq_out | output | 8 | Active-high interrupt line per channel |

## Verification
The assertions check several rules on every cycle:

- outputs stay quiet during reset;
- the unused top byte of the trigger register reads as zero;
- a single-edge pulse never lasts two cycles while the configuration is unchanged;
- an edge-mode channel stays silent two cycles after a reconfiguring write.

Only the bench scenarios can show the rest:

- the exact three-edge latency;
- the routing of specific pads;
- the inversion in level and falling modes;
- the override of the other trigger bits in both-edges mode;
- detection resuming after a flush with an already-high source.

These all depend on the pad history and on the expected cycle numbers.

// File: rtl/gpio_irq_mux_pkg.sv
package gpio_irq_mux_pkg;

    localparam int unsigned NUM_CH     = 8;
    localparam int unsigned SEL_W      = 8;
    localparam int unsigned FILT_W     = 4;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned CH_PER_SEL = BUS_W / SEL_W;
    localparam int unsigned BOTH_OFS   = NUM_CH;
    localparam int unsigned INV_OFS    = 2 * NUM_CH;
    localparam int unsigned MODE_W     = 3 * NUM_CH;

    localparam logic [1:0] IDX_MODE   = 2'd0;
    localparam logic [1:0] IDX_SEL_LO = 2'd1;
    localparam logic [1:0] IDX_SEL_HI = 2'd2;
    localparam logic [1:0] IDX_FILT   = 2'd3;

    typedef enum logic [1:0] {
        ST_FLUSH    = 2'd0,
        ST_WATCH_LO = 2'd1,
        ST_WATCH_HI = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic both;
        logic edge_sel;
        logic invert;
    } chan_cfg_t;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_mux_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [1:0]                        reg_idx,
    input  logic [BUS_W-1:0]                  bus_wdata,
    output logic [BUS_W-1:0]                  bus_rdata,
    output logic [NUM_CH-1:0][SEL_W-1:0]      pad_sel,
    output chan_cfg_t [NUM_CH-1:0]            cfg,
    output logic [NUM_CH-1:0]                 reload
);

    logic [MODE_W-1:0] mode_q;
    logic [BUS_W-1:0]  sel_lo_q;
    logic [BUS_W-1:0]  sel_hi_q;
    logic [BUS_W-1:0]  filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            filt_q   <= '0;
        end else if (bus_we) begin
            unique case (reg_idx)
                IDX_MODE:   mode_q   <= bus_wdata[MODE_W-1:0];
                IDX_SEL_LO: sel_lo_q <= bus_wdata;
                IDX_SEL_HI: sel_hi_q <= bus_wdata;
                IDX_FILT:   filt_q   <= bus_wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_idx)
            IDX_MODE:   bus_rdata = {{(BUS_W-MODE_W){1'b0}}, mode_q};
            IDX_SEL_LO: bus_rdata = sel_lo_q;
            IDX_SEL_HI: bus_rdata = sel_hi_q;
            IDX_FILT:   bus_rdata = filt_q;
            default:    bus_rdata = '0;
        endcase
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
        localparam int unsigned FLD = (c % CH_PER_SEL) * SEL_W;
        if (c < CH_PER_SEL) begin : g_lo
            assign pad_sel[c] = sel_lo_q[FLD +: SEL_W];
            assign reload[c]  = bus_we && (reg_idx == IDX_MODE || reg_idx == IDX_SEL_LO);
        end else begin : g_hi
            assign pad_sel[c] = sel_hi_q[FLD +: SEL_W];
            assign reload[c]  = bus_we && (reg_idx == IDX_MODE || reg_idx == IDX_SEL_HI);
        end
        assign cfg[c].edge_sel = mode_q[c];
        assign cfg[c].both     = mode_q[BOTH_OFS + c];
        assign cfg[c].invert   = mode_q[INV_OFS + c];
    end

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
    import gpio_irq_mux_pkg::*;
#(
    parameter int unsigned NUM_PADS    = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads,
    input  logic [SEL_W-1:0]    sel,
    input  chan_cfg_t           cfg,
    input  logic                reload,
    output logic                irq
);

    localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);

    logic                   raw;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cond;
    logic                   edge_mode;
    chan_state_e            state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic                   fire;

    if (NUM_PADS >= (1 << SEL_W)) begin : g_full_mux
        assign raw = pads[sel];
    end else begin : g_part_mux
        assign raw = (sel < SEL_W'(NUM_PADS)) ? pads[sel] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    assign cond      = sync_q[SYNC_STAGES-1] ^ (cfg.invert & ~cfg.both);
    assign edge_mode = cfg.edge_sel | cfg.both;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLUSH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (reload) begin
            state_d = ST_FLUSH;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_FLUSH: begin
                    if (cnt_q == CNT_W'(SYNC_STAGES)) begin
                        state_d = cond ? ST_WATCH_HI : ST_WATCH_LO;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WATCH_LO: begin
                    if (cond) begin
                        state_d = ST_WATCH_HI;
                        fire    = edge_mode;
                    end
                end
                ST_WATCH_HI: begin
                    if (!cond) begin
                        state_d = ST_WATCH_LO;
                        fire    = cfg.both;
                    end
                end
                default: state_d = ST_FLUSH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq <= 1'b0;
        else if (edge_mode) irq <= fire;
        else                irq <= cond;
    end

endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
    import gpio_irq_mux_pkg::*;
#(
    parameter int unsigned NUM_PADS    = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [1:0]          reg_idx,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pads,
    output logic [7:0]          irq_out
);

    logic [NUM_CH-1:0][SEL_W-1:0] pad_sel;
    chan_cfg_t [NUM_CH-1:0]       cfg;
    logic [NUM_CH-1:0]            reload;

    gpio_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .reg_idx   (reg_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_sel   (pad_sel),
        .cfg       (cfg),
        .reload    (reload)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        gpio_irq_chan #(
            .NUM_PADS    (NUM_PADS),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pads   (pads),
            .sel    (pad_sel[c]),
            .cfg    (cfg[c]),
            .reload (reload[c]),
            .irq    (irq_out[c])
        );
    end

endmodule

// File: rtl/gpio_irq_mux_chk.sv
module gpio_irq_mux_chk
    import gpio_irq_mux_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             reg_idx,
    input logic [31:0]            bus_rdata,
    input chan_cfg_t [NUM_CH-1:0] cfg,
    input logic [NUM_CH-1:0]      reload,
    input logic [7:0]             irq_out
);

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (irq_out == '0) else $error("irq high in reset"); // R1
        end
    end

    AST_MODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_MODE) |-> (bus_rdata[31:MODE_W] == '0)); // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_SINGLE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[c].edge_sel && !cfg[c].both && irq_out[c] && $stable(cfg[c]))
            |=> (!irq_out[c] || !cfg[c].edge_sel || cfg[c].both)); // R7

        AST_RECONFIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            reload[c] |=> ##1 (!irq_out[c] || !(cfg[c].edge_sel || cfg[c].both))); // R10
    end

endmodule

bind gpio_irq_mux gpio_irq_mux_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .reload    (reload),
    .irq_out   (irq_out)
);

// File: tb/gpio_irq_mux_tb.sv
module gpio_irq_mux_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   reg_idx = 2'd0;
    logic [31:0]  bus_wdata = '0;
    wire  [31:0]  bus_rdata;
    logic [255:0] pads = '0;
    wire  [7:0]   irq_out;

    always #10 clk = ~clk;

    gpio_irq_mux u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .reg_idx   (reg_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pads      (pads),
        .irq_out   (irq_out)
    );

    typedef struct {
        int    at;
        int    ch;
        logic  val;
        string req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(bit ok, string req, logic [31:0] act_v,
                                  logic [31:0] exp_v, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act_v, exp_v);
        end
    endfunction

    task automatic expect_at(int at, int ch, logic v, string req);
        exp_t e;
        e.at = at; e.ch = ch; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(irq_out[sb[i].ch] === sb[i].val, sb[i].req,
                      32'(irq_out[sb[i].ch]), 32'(sb[i].val),
                      $sformatf("ch%0d cycle %0d", sb[i].ch, cyc));
                sb.delete(i);
            end
        end
    end

    task automatic wr(logic [1:0] idx, logic [31:0] d, output int w);
        @(negedge clk);
        bus_we = 1'b1; reg_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        w = cyc;
    endtask

    task automatic rd(logic [1:0] idx, logic [31:0] e, string req);
        @(negedge clk);
        reg_idx = idx;
        #1;
        check(bus_rdata === e, req, bus_rdata, e, $sformatf("read idx %0d", idx));
    endtask

    task automatic pad(int i, logic v, output int n);
        @(negedge clk);
        pads[i] = v;
        n = cyc;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        int n;
        int w;
        idle(3);
        check(irq_out === 8'h00, "R1", 32'(irq_out), 0, "outputs in reset");
        rst_n = 1'b1;
        rd(2'd0, 32'h0, "R1");
        rd(2'd1, 32'h0, "R1");
        rd(2'd2, 32'h0, "R1");
        rd(2'd3, 32'h0, "R1");

        wr(2'd0, 32'hFFFF_FFFF, w);
        rd(2'd0, 32'h00FF_FFFF, "R2");
        wr(2'd3, 32'h7654_3210, w);
        rd(2'd3, 32'h7654_3210, "R4");
        idle(4);
        check(irq_out === 8'h00, "R4", 32'(irq_out), 0, "filter write has no effect");

        wr(2'd1, 32'h1E14_0A05, w);
        wr(2'd2, 32'hFF3C_C828, w);
        wr(2'd0, 32'h005A_501C, w);
        rd(2'd1, 32'h1E14_0A05, "R3");
        rd(2'd2, 32'hFF3C_C828, "R3");
        rd(2'd0, 32'h005A_501C, "R2");
        idle(6);
        check(irq_out === 8'h02, "R6", 32'(irq_out), 32'h02, "steady state after config");

        // R5 level mode, active high
        pad(5, 1'b1, n);
        expect_at(n + 2, 0, 1'b0, "R5");
        expect_at(n + 3, 0, 1'b1, "R5");
        expect_at(n + 6, 0, 1'b1, "R5");
        idle(7);
        pad(5, 1'b0, n);
        expect_at(n + 3, 0, 1'b0, "R5");
        idle(5);

        // R3 routing to high pad numbers
        pad(200, 1'b1, n);
        expect_at(n + 3, 5, 1'b1, "R3");
        expect_at(n + 3, 0, 1'b0, "R3");
        pad(255, 1'b1, n);
        expect_at(n + 3, 7, 1'b1, "R3");
        idle(5);
        pad(200, 1'b0, n);
        pad(255, 1'b0, n);
        expect_at(n + 3, 7, 1'b0, "R3");
        idle(5);

        // R6 inverted level
        pad(10, 1'b1, n);
        expect_at(n + 2, 1, 1'b1, "R6");
        expect_at(n + 3, 1, 1'b0, "R6");
        idle(5);
        pad(10, 1'b0, n);
        expect_at(n + 3, 1, 1'b1, "R6");
        idle(5);

        // R7 rising edge
        pad(20, 1'b1, n);
        expect_at(n + 2, 2, 1'b0, "R7");
        expect_at(n + 3, 2, 1'b1, "R7");
        expect_at(n + 4, 2, 1'b0, "R7");
        expect_at(n + 6, 2, 1'b0, "R7");
        idle(7);
        pad(20, 1'b0, n);
        expect_at(n + 3, 2, 1'b0, "R7");
        expect_at(n + 4, 2, 1'b0, "R7");
        idle(5);

        // R8 falling edge
        pad(30, 1'b1, n);
        expect_at(n + 3, 3, 1'b0, "R8");
        expect_at(n + 4, 3, 1'b0, "R8");
        idle(5);
        pad(30, 1'b0, n);
        expect_at(n + 3, 3, 1'b1, "R8");
        expect_at(n + 4, 3, 1'b0, "R8");
        idle(5);

        // R9 both edges, with edge and invert bits also set
        pad(40, 1'b1, n);
        expect_at(n + 3, 4, 1'b1, "R9");
        expect_at(n + 4, 4, 1'b0, "R9");
        idle(5);
        pad(40, 1'b0, n);
        expect_at(n + 3, 4, 1'b1, "R9");
        expect_at(n + 4, 4, 1'b0, "R9");
        idle(5);

        // R9 both edges with edge bit clear: pulse, never a level
        pad(60, 1'b1, n);
        expect_at(n + 3, 6, 1'b1, "R9");
        expect_at(n + 4, 6, 1'b0, "R9");
        expect_at(n + 7, 6, 1'b0, "R9");
        idle(8);
        pad(60, 1'b0, n);
        expect_at(n + 3, 6, 1'b1, "R9");
        idle(5);

        // R10 reselect ch2 onto an already-high pad
        pad(21, 1'b1, n);
        idle(5);
        wr(2'd1, 32'h1E15_0A05, w);
        for (int k = 1; k <= 8; k++) expect_at(w + k, 2, 1'b0, "R10");
        idle(9);
        rd(2'd1, 32'h1E15_0A05, "R3");
        pad(21, 1'b0, n);
        expect_at(n + 3, 2, 1'b0, "R10");
        idle(5);
        pad(21, 1'b1, n);
        expect_at(n + 3, 2, 1'b1, "R10");
        expect_at(n + 4, 2, 1'b0, "R10");
        idle(10);

        check(sb.size() == 0, "R10", 32'(sb.size()), 0, "unconsumed expectations");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule